// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block models the write path of a byte-wide, page-organised nonvolatile memory. It runs on a fast system clock and samples three active-low strobes: chip select, write strobe and output enable. Each strobe passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. A write pulse is the window in which chip select and write strobe are both low. Each valid write pulse loads one byte into a 128-byte page buffer. Once no new load arrives for a set number of cycles, the block copies the buffer into a small on-chip array model, starts a program cycle and keeps a busy level high for a programmable number of cycles.

A separate command decoder drives a write-allow input that decides whether a byte load is accepted. A status unit watches the single-cycle program-start pulse and the busy level. A registered read port returns the array byte at the current address. The array model holds `NUM_PAGES` pages, and higher page numbers wrap onto them.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, busy and program_start are 0 and every array byte reads FFH.
- R2: A write pulse loads a byte only if output enable is high and the pulse stays active for at least `MIN_LOW_CYC` synchronized cycles. A shorter pulse has no effect.
- R3: The address is taken when the second strobe of the pair falls. The data is taken when the first strobe of the pair rises. Address or data changes at other points in the pulse are not stored.
- R4: Address bits 6..0 select the buffer offset, and a second load to the same offset replaces the first. The page that is programmed is given by address bits 16..7 of the last accepted load.
- R5: A program cycle starts `BLCO_CYC` cycles after the last accepted load, plus the synchronizer latency. A load that arrives before that keeps the page-load phase open, with no limit on the number of loads.
- R6: program_start is high for exactly one cycle, in the same cycle that busy rises. busy then stays high for exactly `PROG_CYC` cycles.
- R7: In the programmed page, offsets that were not loaded become FFH. All other pages keep their contents.
- R8: A load that arrives while busy is high is dropped. It is not stored and it does not start a new program cycle.
- R9: If output enable goes low at any time during a write pulse, the load is inhibited. If write-allow is low when the pulse ends, the load is ignored.
- R10: rd_data shows the array byte at addr one clock after addr is applied. Page numbers select array page (page mod `NUM_PAGES`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 17 | Byte address: page in bits 16..7, offset in bits 6..0 |
| din | input | 8 | Write data |
| wr_allow | input | 1 | From the command decoder: byte loads are permitted |
| rd_data | output | 8 | Registered array byte at addr |
| busy | output | 1 | High while a program cycle runs |
| program_start | output | 1 | One-cycle pulse when a program cycle begins |

## Verification
Most faults in the sequencer state show up as a change in the time from the last load to the rise of busy, or in the number of busy cycles. The bench measures both on every program cycle, so a wrong timer or an extra state is caught within one page write. Faults in the page buffer or the array, such as a lost valid bit, a wrong page index or an offset written twice, appear only when the array is read back. After each commit the bench reads the whole array, so each of these faults shows up on the first page written after it occurs. A load that is wrongly accepted, such as a glitch, an inhibited pulse or a load during busy, produces an unexpected rise of busy about `BLCO_CYC` cycles later.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int ADDR_W     = 17;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 7;
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } wr_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
    } byte_load_t;

    function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

endpackage

// File: rtl/pgwr_sync.sv
module pgwr_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
            end else begin
                s1_q <= d_in[g];
                s2_q <= s1_q;
            end
        end
        assign d_out[g] = s2_q;
    end
endmodule

// File: rtl/pgwr_loader.sv
module pgwr_loader
    import pgwr_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              accept,
    output logic              load_valid,
    output byte_load_t        load_o
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);

    logic              act, act_q, inhib_q;
    logic [CW-1:0]     low_cnt_q;
    logic [ADDR_W-1:0] addr_q;

    assign act = ~ce_s & ~we_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            inhib_q   <= 1'b0;
            low_cnt_q <= '0;
            addr_q    <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                addr_q    <= addr;
                low_cnt_q <= CW'(1);
                inhib_q   <= ~oe_s;
            end else if (act) begin
                if (low_cnt_q < CW'(MIN_LOW_CYC))
                    low_cnt_q <= low_cnt_q + CW'(1);
                if (!oe_s)
                    inhib_q <= 1'b1;
            end
        end
    end

    assign load_valid = act_q & ~act & ~inhib_q & oe_s & accept
                      & (low_cnt_q >= CW'(MIN_LOW_CYC));
    assign load_o = '{page: page_of(addr_q), ofs: ofs_of(addr_q), data: din};
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf
    import pgwr_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load_valid,
    input  byte_load_t                          load_i,
    input  logic                                clear,
    output logic [PAGE_W-1:0]                   page_o,
    output logic [PAGE_BYTES-1:0]               valid_o,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]   img_o
);
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
    logic [PAGE_BYTES-1:0]             valid_q;
    logic [PAGE_W-1:0]                 page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= '0;
            page_q  <= '0;
        end else if (load_valid) begin
            data_q[load_i.ofs]  <= load_i.data;
            valid_q[load_i.ofs] <= 1'b1;
            page_q              <= load_i.page;
        end else if (clear) begin
            valid_q <= '0;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_img
        assign img_o[g] = valid_q[g] ? data_q[g] : {DATA_W{1'b1}};
    end

    assign page_o  = page_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int NUM_PAGES = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit,
    input  logic [PAGE_W-1:0]                 wr_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] wr_img,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int SLOT_W = $clog2(NUM_PAGES);
    localparam int IDX_W  = SLOT_W + OFS_W;
    localparam int DEPTH  = NUM_PAGES * PAGE_BYTES;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [SLOT_W-1:0] wr_slot, rd_slot;

    assign wr_slot = SLOT_W'(wr_page % PAGE_W'(NUM_PAGES));
    assign rd_slot = SLOT_W'(page_of(rd_addr) % PAGE_W'(NUM_PAGES));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= {DATA_W{1'b1}};
            rd_data <= {DATA_W{1'b1}};
        end else begin
            if (commit)
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem_q[IDX_W'({wr_slot, OFS_W'(i)})] <= wr_img[i];
            rd_data <= mem_q[IDX_W'({rd_slot, ofs_of(rd_addr)})];
        end
    end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2,
    parameter int BLCO_CYC    = 20000,
    parameter int PROG_CYC    = 500000,
    parameter int NUM_PAGES   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_allow,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              program_start
);
    localparam int IW = $clog2(BLCO_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);

    logic [2:0]                        strobe_s;
    logic                              load_valid, accept, commit;
    byte_load_t                        load;
    logic [PAGE_W-1:0]                 buf_page;
    logic [PAGE_BYTES-1:0]             buf_valid;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_img;
    wr_state_e                         state_q;
    logic [IW-1:0]                     idle_q;
    logic [PW-1:0]                     prog_q;

    pgwr_sync #(.N(3)) u_sync (
        .clk(clk), .rst(rst),
        .d_in({oe_n, we_n, ce_n}),
        .d_out(strobe_s)
    );

    pgwr_loader #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_loader (
        .clk(clk), .rst(rst),
        .ce_s(strobe_s[0]), .we_s(strobe_s[1]), .oe_s(strobe_s[2]),
        .addr(addr), .din(din), .accept(accept),
        .load_valid(load_valid), .load_o(load)
    );

    pgwr_pagebuf u_buf (
        .clk(clk), .rst(rst),
        .load_valid(load_valid), .load_i(load), .clear(commit),
        .page_o(buf_page), .valid_o(buf_valid), .img_o(buf_img)
    );

    pgwr_array #(.NUM_PAGES(NUM_PAGES)) u_array (
        .clk(clk), .rst(rst),
        .commit(commit), .wr_page(buf_page), .wr_img(buf_img),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign accept = wr_allow & (state_q != ST_PROG);
    assign commit = (state_q == ST_LOAD) && !load_valid
                 && (idle_q == IW'(BLCO_CYC - 1));
    assign busy   = (state_q == ST_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            idle_q        <= '0;
            prog_q        <= '0;
            program_start <= 1'b0;
        end else begin
            program_start <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (load_valid) begin
                    state_q <= ST_LOAD;
                    idle_q  <= '0;
                end
                ST_LOAD: begin
                    if (load_valid) begin
                        idle_q <= '0;
                    end else if (commit) begin
                        state_q       <= ST_PROG;
                        prog_q        <= PW'(PROG_CYC - 1);
                        program_start <= 1'b1;
                    end else begin
                        idle_q <= idle_q + IW'(1);
                    end
                end
                ST_PROG: begin
                    if (prog_q == '0) state_q <= ST_IDLE;
                    else              prog_q  <= prog_q - PW'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
    parameter int PROG_CYC   = 500000,
    parameter int PAGE_BYTES = 128
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  program_start,
    input logic                  load_valid,
    input logic [PAGE_BYTES-1:0] buf_valid
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) busy_cnt <= 0;
        else     busy_cnt <= busy ? busy_cnt + 1 : 0;
    end

    a_r6_start_with_busy: assert property (@(posedge clk) disable iff (rst)
        program_start |-> busy);

    a_r6_busy_rise_has_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> program_start);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        program_start |=> !program_start);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_cnt == PROG_CYC);

    a_r8_no_load_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load_valid);

    a_r8_buffer_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(buf_valid));
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.PROG_CYC(PROG_CYC), .PAGE_BYTES(pgwr_pkg::PAGE_BYTES)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .program_start(program_start),
    .load_valid(load_valid), .buf_valid(buf_valid)
);

// File: tb/pgwr_ctrl_test.sv
module pgwr_ctrl_test;
    localparam int MINL = 4;
    localparam int BLCO = 60;
    localparam int PROG = 100;
    localparam int NP   = 4;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wr_allow = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  rd_data;
    logic        busy, program_start;

    int tests = 0, fails = 0, cyc = 0;

    logic [7:0] ref_mem [NP*128];
    logic [7:0] ref_buf [128];
    bit         ref_vld [128];
    int         ref_page = 0;

    pgwr_ctrl #(.MIN_LOW_CYC(MINL), .BLCO_CYC(BLCO), .PROG_CYC(PROG), .NUM_PAGES(NP)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_allow(wr_allow),
        .rd_data(rd_data), .busy(busy), .program_start(program_start)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            tests++; fails++;
            $display("FAIL R6 watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write-strobe-controlled load; optional one-cycle output-enable dip mid pulse.
    task automatic do_load(input logic [16:0] a, input logic [7:0] d, input int len, input bit oe_dip);
        addr = a; din = d; ce_n = 1'b0;
        tick(1);
        we_n = 1'b0;
        if (oe_dip) begin
            tick(2); oe_n = 1'b0; tick(1); oe_n = 1'b1; tick(len - 3);
        end else begin
            tick(len);
        end
        we_n = 1'b1;
        tick(3);
        ce_n = 1'b1;
        tick(3);
    endtask

    task automatic model_load(input logic [16:0] a, input logic [7:0] d);
        ref_buf[a[6:0]] = d;
        ref_vld[a[6:0]] = 1'b1;
        ref_page = int'(a[16:7]);
    endtask

    task automatic model_commit();
        for (int i = 0; i < 128; i++) begin
            ref_mem[(ref_page % NP) * 128 + i] = ref_vld[i] ? ref_buf[i] : 8'hFF;
            ref_vld[i] = 1'b0;
        end
    endtask

    task automatic verify_array(input string req, input int alias_pg);
        int bad = 0;
        for (int i = 0; i < NP*128; i++) begin
            addr = 17'(i + alias_pg * NP * 128);
            tick(2);
            if (rd_data !== ref_mem[i]) begin
                if (bad == 0)
                    $display("  first mismatch idx %0d: got %h want %h", i, rd_data, ref_mem[i]);
                bad++;
            end
        end
        check(req, bad, 0, "array bytes differing from model");
    endtask

    task automatic expect_idle(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (busy) seen = 1;
        end
        check(req, seen, 0, "busy seen with no accepted load");
    endtask

    task automatic wait_program();
        int lat = 0, blen = 0, pw = 0;
        while (!busy && lat < BLCO + 40) begin tick(1); lat++; end
        tests++;
        if (lat < BLCO - 8 || lat > BLCO + 2) begin
            fails++;
            $display("FAIL R5 start latency: actual %0d expected %0d..%0d", lat, BLCO - 8, BLCO + 2);
        end
        check("R6", int'(program_start), 1, "start pulse at busy rise");
        while (busy && blen < PROG + 40) begin
            tick(1); blen++;
            if (program_start) pw++;
        end
        check("R6", blen, PROG, "busy length");
        check("R6", pw, 0, "start pulse longer than one cycle");
        model_commit();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1DEA5);
        for (int i = 0; i < NP*128; i++) ref_mem[i] = 8'hFF;
        for (int i = 0; i < 128; i++) ref_vld[i] = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1: reset state
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(program_start), 0, "program_start after reset");
        verify_array("R1", 0);

        // R4/R7: page 5 (slot 1), repeated offset overwrites
        do_load({10'd5, 7'd0},   8'h11, 6, 0); model_load({10'd5, 7'd0},   8'h11);
        do_load({10'd5, 7'd7},   8'h22, 6, 0); model_load({10'd5, 7'd7},   8'h22);
        do_load({10'd5, 7'd127}, 8'h33, 6, 0); model_load({10'd5, 7'd127}, 8'h33);
        do_load({10'd5, 7'd7},   8'h44, 6, 0); model_load({10'd5, 7'd7},   8'h44);
        wait_program();
        verify_array("R7", 0);

        // R5/R4: loads spaced under the timeout keep the phase open; last page wins
        do_load({10'd2, 7'd3}, 8'hA1, 6, 0); model_load({10'd2, 7'd3}, 8'hA1);
        tick(BLCO - 25);
        check("R5", int'(busy), 0, "programming before timeout");
        do_load({10'd3, 7'd9}, 8'hB2, 6, 0); model_load({10'd3, 7'd9}, 8'hB2);
        tick(BLCO - 25);
        check("R5", int'(busy), 0, "programming before timeout");
        do_load({10'd3, 7'd10}, 8'hC3, 6, 0); model_load({10'd3, 7'd10}, 8'hC3);
        wait_program();
        verify_array("R4", 0);

        // R3: address at later fall, data at first rise
        addr = {10'd0, 7'd50}; din = 8'h5A; ce_n = 1'b0; tick(4);
        addr = {10'd0, 7'd20}; tick(4);
        we_n = 1'b0; tick(4);
        addr = {10'd0, 7'd60}; tick(4);
        ce_n = 1'b1; tick(4);
        din = 8'hE7; tick(2);
        we_n = 1'b1; tick(4);
        model_load({10'd0, 7'd20}, 8'h5A);
        wait_program();
        verify_array("R3", 0);

        // R2: short pulse rejected
        do_load({10'd1, 7'd1}, 8'h99, 2, 0);
        expect_idle("R2", BLCO + 20);
        // R9: output enable dip and write-allow low
        do_load({10'd1, 7'd2}, 8'h98, 8, 1);
        expect_idle("R9", BLCO + 20);
        wr_allow = 1'b0;
        do_load({10'd1, 7'd3}, 8'h97, 6, 0);
        wr_allow = 1'b1;
        expect_idle("R9", BLCO + 20);
        verify_array("R2", 0);

        // R8: load during busy is dropped
        do_load({10'd2, 7'd4}, 8'h76, 6, 0); model_load({10'd2, 7'd4}, 8'h76);
        while (!busy) tick(1);
        tick(10);
        do_load({10'd1, 7'd5}, 8'h65, 6, 0);
        while (busy) tick(1);
        model_commit();
        expect_idle("R8", BLCO + 20);
        verify_array("R8", 0);

        // Random page writes
        for (int r = 0; r < 4; r++) begin
            int n;
            logic [9:0] base;
            n = 1 + $urandom_range(15);
            base = 10'($urandom_range(1023));
            for (int k = 0; k < n; k++) begin
                logic [16:0] a;
                logic [7:0]  d;
                a = {($urandom_range(3) == 0) ? 10'($urandom_range(1023)) : base,
                     7'($urandom_range(127))};
                d = 8'($urandom_range(255));
                do_load(a, d, 5 + $urandom_range(3), 0);
                model_load(a, d);
            end
            wait_program();
            verify_array("R7", 0);
        end

        // R10: aliased page numbers read the same slots
        verify_array("R10", 5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule